// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. It runs nine instructions: load word, store word, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and jump. Each cycle it fetches the word addressed by the program counter. It reads up to two registers, works out a result or an address in the ALU, and then does one of three things: writes a register, writes data memory, or picks a new program counter.

The opcode drives a main decoder. That decoder produces the datapath selects and a 2-bit operation class. A second decoder combines the class with the function field to choose one of five 3-bit ALU codes.

Instruction memory and data memory are small internal word arrays. They are loaded through a preload port, normally while reset is held. Every register write and memory write the core makes shows up on observation ports in the cycle that the instruction executes.

Top module: `onecyc_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. While reset is high, neither the register-write nor the memory-write strobe is asserted.
- R2: An instruction that is neither a taken branch nor a jump makes the next program counter equal to the current one plus 4.
- R3: Opcode 000000 is register-to-register. The result goes to register bits [15:11]. The function field [5:0] selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than. Set-less-than gives 1 when the first operand is smaller as a signed number and 0 otherwise.
- R4: Register 0 always reads as zero. A write to register 0 is dropped and no register-write strobe is shown for it.
- R5: Load (opcode 100011) reads the data word at the address register[25:21] plus the offset. It writes that word to register [20:16].
- R6: Store (opcode 101011) writes register [20:16] to the data word at register[25:21] plus the offset. It writes no register.
- R7: The 16-bit offset in bits [15:0] is sign-extended from bit 15 before it is used, so negative offsets work.
- R8: Branch-if-equal (opcode 000100) compares registers [25:21] and [20:16]. If they are equal, the next program counter is (PC+4) + (sign-extended offset × 4). Otherwise it is PC+4.
- R9: Jump (opcode 000010) sets the next program counter to the top 4 bits of PC+4, then bits [25:0], then two zero bits.
- R10: Register reads are combinational. A value written by one instruction is visible to the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Preload write strobe |
| prog_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| prog_addr | input | IDX_W | Preload word index |
| prog_data | input | 32 | Preload word |
| pc_o | output | 32 | Program counter of the executing instruction |
| rf_we_o | output | 1 | Register write taking place this cycle |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Register write value |
| dm_we_o | output | 1 | Data memory write taking place this cycle |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Data memory write value |

## Verification
In a branch-if-equal, the equality test in the ALU and the target addition happen in the same cycle, and together they decide the program counter of the next cycle. The bench provokes this with three cases:
- a branch whose operands differ;
- a forward branch whose operands match, including one operand taken from a register that was just written through register 0;
- a backward branch that targets itself.

The program counter is judged on each of the following cycles. A store whose address uses a negative offset also combines sign extension and the address addition in one cycle. The address and data of that store are compared, and a following load reads the same word back.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef struct packed {
        logic     dst_is_rd;
        logic     reg_write;
        logic     b_is_imm;
        logic     mem_read;
        logic     mem_write;
        logic     wb_from_mem;
        logic     branch;
        logic     jump;
        alu_cls_e cls;
    } ctrl_t;

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{default: '0, cls: CLS_ADD};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.cls       = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.mem_read    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_SUB;
            end
            OPC_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
    import core_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_sel_e   sel
);
    always_comb begin
        sel = ALU_ADD;
        case (cls)
            CLS_SUB: sel = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_SUB:  sel = ALU_SUB;
                    FN_AND:  sel = ALU_AND;
                    FN_OR:   sel = ALU_OR;
                    FN_SLT:  sel = ALU_SLT;
                    default: sel = ALU_ADD;
                endcase
            end
            default: sel = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] diff;

    always_comb begin
        diff = a - b;
        case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0) regs_d[wa] = wd;
        rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{default: '0};
        else     regs_q <= regs_d;
    end
endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
    import core_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_we,
    input  logic             prog_dmem,
    input  logic [IDX_W-1:0] prog_addr,
    input  logic [XLEN-1:0]  prog_data,
    output logic [XLEN-1:0]  pc_o,
    output logic             rf_we_o,
    output logic [RIDX-1:0]  rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } fetch_t;

    fetch_t st_d, st_q;
    logic [XLEN-1:0] imem_d [MEM_WORDS];
    logic [XLEN-1:0] imem_q [MEM_WORDS];
    logic [XLEN-1:0] dmem_d [MEM_WORDS];
    logic [XLEN-1:0] dmem_q [MEM_WORDS];

    logic [XLEN-1:0] instr, rd1, rd2, imm_ext, alu_b, alu_y;
    logic [XLEN-1:0] dm_rdata, wb_data, pc_plus4, br_tgt, j_tgt;
    logic [IDX_W-1:0] dm_idx;
    logic [RIDX-1:0] wa;
    logic            alu_zero, rf_we, take_br;
    ctrl_t           ctrl;
    alu_sel_e        alu_sel;

    assign instr = imem_q[st_q.pc[IDX_W+1:2]];

    core_main_dec u_main_dec (
        .opcode(instr[31:26]),
        .ctrl  (ctrl)
    );

    core_alu_dec u_alu_dec (
        .cls  (ctrl.cls),
        .funct(instr[5:0]),
        .sel  (alu_sel)
    );

    core_regfile #(.W(XLEN), .NREG(32)) u_rf (
        .clk(clk),
        .rst(rst),
        .ra1(instr[25:21]),
        .ra2(instr[20:16]),
        .rd1(rd1),
        .rd2(rd2),
        .we (rf_we),
        .wa (wa),
        .wd (wb_data)
    );

    core_alu #(.W(XLEN)) u_alu (
        .a   (rd1),
        .b   (alu_b),
        .sel (alu_sel),
        .y   (alu_y),
        .zero(alu_zero)
    );

    always_comb begin
        imm_ext  = {{(XLEN-16){instr[15]}}, instr[15:0]};
        alu_b    = ctrl.b_is_imm ? imm_ext : rd2;
        dm_idx   = alu_y[IDX_W+1:2];
        dm_rdata = ctrl.mem_read ? dmem_q[dm_idx] : '0;
        wb_data  = ctrl.wb_from_mem ? dm_rdata : alu_y;
        wa       = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
        rf_we    = ctrl.reg_write & ~rst;
        pc_plus4 = st_q.pc + XLEN'(4);
        br_tgt   = pc_plus4 + (imm_ext << 2);
        j_tgt    = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
        take_br  = ctrl.branch & alu_zero;
    end

    always_comb begin
        st_d = st_q;
        if (rst)               st_d.pc = '0;
        else if (ctrl.jump)    st_d.pc = j_tgt;
        else if (take_br)      st_d.pc = br_tgt;
        else                   st_d.pc = pc_plus4;

        imem_d = imem_q;
        if (prog_we && !prog_dmem) imem_d[prog_addr] = prog_data;

        dmem_d = dmem_q;
        if (prog_we && prog_dmem)          dmem_d[prog_addr] = prog_data;
        else if (ctrl.mem_write && !rst)   dmem_d[dm_idx]    = rd2;
    end

    always_ff @(posedge clk) begin
        st_q   <= st_d;
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign pc_o       = st_q.pc;
    assign rf_we_o    = rf_we && (wa != '0);
    assign rf_waddr_o = wa;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctrl.mem_write & ~rst;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;
endmodule

// File: rtl/onecyc_core_chk.sv
module onecyc_core_chk
    import core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] instr,
    input logic [XLEN-1:0] rs_data,
    input logic [XLEN-1:0] rt_data,
    input logic            rf_we_o,
    input logic            dm_we_o
);
    logic [XLEN-1:0] nxt_seq, nxt_br, nxt_j;
    logic            is_flow;

    always_comb begin
        nxt_seq = pc_o + 32'd4;
        nxt_br  = nxt_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
        nxt_j   = {nxt_seq[31:28], instr[25:0], 2'b00};
        is_flow = (instr[31:26] == OPC_BEQ) || (instr[31:26] == OPC_JUMP);
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> pc_o == '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !is_flow |=> pc_o == $past(nxt_seq));

    // R8
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BEQ && rs_data == rt_data) |=> pc_o == $past(nxt_br));

    // R8
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_BEQ && rs_data != rt_data) |=> pc_o == $past(nxt_seq));

    // R9
    jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_JUMP) |=> pc_o == $past(nxt_j));

    // R6
    store_noreg_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);
endmodule

bind onecyc_core onecyc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc_o   (pc_o),
    .instr  (instr),
    .rs_data(rd1),
    .rt_data(rd2),
    .rf_we_o(rf_we_o),
    .dm_we_o(dm_we_o)
);

// File: tb/onecyc_core_bench.sv
module onecyc_core_bench;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             prog_we = 1'b0;
    logic             prog_dmem = 1'b0;
    logic [IDX_W-1:0] prog_addr = '0;
    logic [31:0]      prog_data = '0;
    logic [31:0]      pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]       rf_waddr_o;
    logic             rf_we_o, dm_we_o;

    always #5 clk = ~clk;

    onecyc_core #(.MEM_WORDS(64)) u_onecyc_core (
        .clk(clk), .rst(rst),
        .prog_we(prog_we), .prog_dmem(prog_dmem),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    typedef struct {
        logic [31:0] pc;
        bit          rfw;
        logic [4:0]  ra;
        logic [31:0] rd;
        bit          dmw;
        logic [31:0] da;
        logic [31:0] dd;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   started = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic put_word(input bit to_dmem, input int idx, input logic [31:0] w);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_dmem = to_dmem;
        prog_addr = IDX_W'(idx);
        prog_data = w;
    endtask

    task automatic push(input logic [31:0] pc, input bit rfw, input int ra, input logic [31:0] rd,
                        input bit dmw, input logic [31:0] da, input logic [31:0] dd, input string req);
        exp_t e;
        e.pc = pc; e.rfw = rfw; e.ra = 5'(ra); e.rd = rd;
        e.dmw = dmw; e.da = da; e.dd = dd; e.req = req;
        exp_q.push_back(e);
    endtask

    localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BQ = 6'b000100;

    // driver: preload, reset check, expected stream
    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pc_o == 32'h0, "R1 pc in reset", pc_o, 32'h0);
        chk(!rf_we_o && !dm_we_o, "R1 strobes in reset", {30'b0, rf_we_o, dm_we_o}, 32'h0);

        put_word(1, 0, 32'd7);
        put_word(1, 1, 32'hFFFF_FFFD);
        put_word(0, 0,  enc_i(LW, 0, 1, 0));
        put_word(0, 1,  enc_i(LW, 0, 2, 4));
        put_word(0, 2,  enc_r(1, 2, 3, 6'b100000));
        put_word(0, 3,  enc_r(1, 2, 4, 6'b100010));
        put_word(0, 4,  enc_r(1, 2, 5, 6'b100100));
        put_word(0, 5,  enc_r(1, 2, 6, 6'b100101));
        put_word(0, 6,  enc_r(2, 1, 7, 6'b101010));
        put_word(0, 7,  enc_r(1, 2, 8, 6'b101010));
        put_word(0, 8,  enc_r(1, 1, 0, 6'b100000));
        put_word(0, 9,  enc_r(0, 1, 9, 6'b100000));
        put_word(0, 10, enc_i(SW, 3, 3, 4));
        put_word(0, 11, enc_i(SW, 3, 6, -4));
        put_word(0, 12, enc_i(LW, 0, 10, 0));
        put_word(0, 13, enc_i(BQ, 1, 2, 5));
        put_word(0, 14, enc_i(BQ, 1, 9, 2));
        put_word(0, 15, enc_r(1, 1, 11, 6'b100000));
        put_word(0, 16, enc_r(1, 1, 11, 6'b100000));
        put_word(0, 17, {6'b000010, 26'h14});
        put_word(0, 18, enc_r(1, 1, 12, 6'b100000));
        put_word(0, 19, enc_r(1, 1, 12, 6'b100000));
        put_word(0, 20, enc_i(BQ, 0, 0, -1));
        @(negedge clk);
        prog_we = 1'b0;

        push(32'h00, 1, 1, 32'd7,          0, 0, 0, "R5 load");
        push(32'h04, 1, 2, 32'hFFFF_FFFD,  0, 0, 0, "R5 load");
        push(32'h08, 1, 3, 32'd4,          0, 0, 0, "R3 R10 add");
        push(32'h0C, 1, 4, 32'd10,         0, 0, 0, "R3 sub");
        push(32'h10, 1, 5, 32'd5,          0, 0, 0, "R3 and");
        push(32'h14, 1, 6, 32'hFFFF_FFFF,  0, 0, 0, "R3 or");
        push(32'h18, 1, 7, 32'd1,          0, 0, 0, "R3 slt true");
        push(32'h1C, 1, 8, 32'd0,          0, 0, 0, "R3 slt false");
        push(32'h20, 0, 0, 0,              0, 0, 0, "R4 write r0");
        push(32'h24, 1, 9, 32'd7,          0, 0, 0, "R4 read r0");
        push(32'h28, 0, 0, 0, 1, 32'd8, 32'd4,          "R6 store");
        push(32'h2C, 0, 0, 0, 1, 32'd0, 32'hFFFF_FFFF,  "R7 negative offset");
        push(32'h30, 1, 10, 32'hFFFF_FFFF, 0, 0, 0, "R5 load after store");
        push(32'h34, 0, 0, 0,              0, 0, 0, "R2 beq not taken");
        push(32'h38, 0, 0, 0,              0, 0, 0, "R8 beq taken");
        push(32'h44, 0, 0, 0,              0, 0, 0, "R8 forward target");
        push(32'h50, 0, 0, 0,              0, 0, 0, "R9 jump target");
        push(32'h50, 0, 0, 0,              0, 0, 0, "R8 backward self");
        push(32'h50, 0, 0, 0,              0, 0, 0, "R8 backward self");

        @(posedge clk);
        #2 rst = 1'b0;
        started = 1'b1;
    end

    // monitor: pops one expected item per executed instruction
    initial begin
        exp_t e;
        wait (started);
        forever begin
            @(negedge clk);
            if (!rst && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(pc_o == e.pc, {e.req, " pc"}, pc_o, e.pc);
                chk(rf_we_o == e.rfw, {e.req, " reg strobe"}, 32'(rf_we_o), 32'(e.rfw));
                if (e.rfw) begin
                    chk(rf_waddr_o == e.ra, {e.req, " reg num"}, 32'(rf_waddr_o), 32'(e.ra));
                    chk(rf_wdata_o == e.rd, {e.req, " reg data"}, rf_wdata_o, e.rd);
                end
                chk(dm_we_o == e.dmw, {e.req, " mem strobe"}, 32'(dm_we_o), 32'(e.dmw));
                if (e.dmw) begin
                    chk(dm_addr_o == e.da, {e.req, " mem addr"}, dm_addr_o, e.da);
                    chk(dm_wdata_o == e.dd, {e.req, " mem data"}, dm_wdata_o, e.dd);
                end
                if (exp_q.size() == 0) done = 1'b1;
            end
        end
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %h expected %h", 32'(exp_q.size()), 32'h0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule